// File: doc/BRIEF.md
# Scanline Playfield Bit Serializer

This block produces the coarse background pattern of a video scan line. Software loads three write-only pattern registers and one control register through a small write port. From the horizontal pixel count, the block picks one of 20 pattern bits for each half of the 160-pixel visible line. Each bit is held for four pixel clocks. The bits are read from the three registers in a fixed mixed order.

The right half of the line either repeats the left half or mirrors it, under a control bit. The block also drives two side-band outputs for a downstream mixer. One is a colour-select code: the playfield colour normally, or in score mode player 0's colour on the left half and player 1's colour on the right half. The other is a priority flag that places the playfield in front of the players. Colour lookup, movable objects and sync timing live elsewhere.

The pattern output and colour select are combinational from the pixel count and the stored registers. A register write captured at a clock edge therefore shows up from that edge on.

Top module: `pf_serializer`

## Requirements
- R1: After reset, all pattern and control bits are 0, so `pf_on` is 0, `col_sel` is 2'b00 and `pf_front` is 0 for every pixel count.
- R2: A write happens at a rising clock edge while `wr_en` is 1. `wr_addr` 0 selects pattern A, 1 selects pattern B, 2 selects pattern C and 3 selects control. Writes to addresses 4 to 7 change nothing.
- R3: The visible line is pixel counts 0 to 159. Each half holds 20 pattern slots of 4 consecutive counts each, with slot = (count mod 80) / 4.
- R4: In the left half, slots 0-3 show A bits 4,5,6,7, slots 4-11 show B bits 7 down to 0, and slots 12-19 show C bits 0 to 7.
- R5: With control bit 0 (mirror) clear, right-half slot k shows the same bit as left-half slot k.
- R6: With control bit 0 set, right-half slot k shows the bit of left-half slot 19-k. The right half thus runs C7..C0, then B0..B7, then A7..A4.
- R7: With control bit 1 (score) set, `col_sel` is 2'b01 for counts 0-79 and 2'b10 for counts 80-159. Otherwise, and at all counts of 160 or more, `col_sel` is 2'b00.
- R8: `pf_front` equals control bit 2 (playfield in front of players).
- R9: For pixel counts of 160 and above, `pf_on` is 0.
- R10: Bits 3 to 0 of pattern A are neither stored nor shown.
- R11: A write made in the middle of a line leaves `pf_on` unchanged until the capturing clock edge and changes it from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 A, 1 B, 2 C, 3 control |
| wr_data | input | 8 | Write data |
| hcount | input | 8 | Horizontal pixel count, 0-159 visible |
| pf_on | output | 1 | Playfield pixel present |
| col_sel | output | 2 | Colour select: 00 playfield, 01 player 0, 10 player 1 |
| pf_front | output | 1 | Playfield drawn in front of players |

## Verification
Several properties are checked on every cycle. Blanking outside the visible line is one. The colour select must never name two sources at once and may only be non-zero on the visible line. The priority flag must follow the last control write. The pattern bit must also stay constant across the four counts of a slot while no write occurs. The slot order in each half, the mirror and repeat layouts, the ignored low nibble and ignored addresses, and the exact edge at which a mid-line write appears can only be shown by the bench. It sweeps whole lines under varied register contents and makes directed spot checks.

// File: rtl/pf_serializer.sv
module pf_serializer #(
  parameter int HCW    = 8,
  parameter int LINE   = 160,
  parameter int BITCLK = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_addr,
  input  logic [7:0]     wr_data,
  input  logic [HCW-1:0] hcount,
  output logic           pf_on,
  output logic [1:0]     col_sel,
  output logic           pf_front
);
  localparam int HALF  = LINE / 2;
  localparam int NBITS = HALF / BITCLK;
  localparam int BSH   = $clog2(BITCLK);
  localparam int IW    = $clog2(NBITS);
  localparam logic [2:0] ADR_A = 3'd0;
  localparam logic [2:0] ADR_B = 3'd1;
  localparam logic [2:0] ADR_C = 3'd2;
  localparam logic [2:0] ADR_K = 3'd3;

  logic [3:0] pat_a;
  logic [7:0] pat_b, pat_c;
  logic [2:0] ctl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pat_a <= '0;
      pat_b <= '0;
      pat_c <= '0;
      ctl   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_A:   pat_a <= wr_data[7:4];
        ADR_B:   pat_b <= wr_data;
        ADR_C:   pat_c <= wr_data;
        ADR_K:   ctl   <= wr_data[2:0];
        default: ;
      endcase
    end
  end

  logic [NBITS-1:0] seq;
  assign seq[3:0]   = pat_a;
  assign seq[19:12] = pat_c;
  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign seq[4+i] = pat_b[7-i];
  end

  logic           vis, right;
  logic [HCW-1:0] pos;
  logic [IW-1:0]  slot, pick;

  assign vis   = hcount < HCW'(LINE);
  assign right = hcount >= HCW'(HALF);
  assign pos   = right ? hcount - HCW'(HALF) : hcount;
  assign slot  = IW'(pos >> BSH);
  assign pick  = (right && ctl[0]) ? IW'(NBITS - 1) - slot : slot;

  assign pf_on    = vis && seq[pick];
  assign col_sel  = (vis && ctl[1]) ? (right ? 2'b10 : 2'b01) : 2'b00;
  assign pf_front = ctl[2];

  p_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount >= HCW'(LINE)) |-> !pf_on);

  p_colsel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel) && ((col_sel != 2'b00) -> (hcount < HCW'(LINE))));

  p_front_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_K) |=> (pf_front == $past(wr_data[2])));

  p_slot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hcount == $past(hcount) + HCW'(1) && hcount[BSH-1:0] != '0 && !$past(wr_en))
      |-> (pf_on == $past(pf_on)));
endmodule

// File: tb/pf_serializer_tb_top.sv
module pf_serializer_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] hcount = 0;
  logic       pf_on;
  logic [1:0] col_sel;
  logic       pf_front;
  int         n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  pf_serializer dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hcount(hcount), .pf_on(pf_on), .col_sel(col_sel),
    .pf_front(pf_front));

  // {A, B, C, control}
  localparam logic [31:0] VEC [8] = '{
    32'hF0_00_00_00, 32'h00_FF_00_00, 32'h00_00_FF_01, 32'h50_A5_3C_00,
    32'hA0_5A_C3_01, 32'h3F_81_7E_02, 32'hC0_13_E8_07, 32'hFF_FF_FF_05 };

  function automatic logic ref_bit(logic [7:0] a, b, c, logic mir, int h);
    int k;
    if (h >= 160) return 1'b0;
    k = (h % 80) / 4;
    if (h >= 80 && mir) k = 19 - k;
    if (k < 4) return a[4+k];
    if (k < 12) return b[11-k];
    return c[k-12];
  endfunction

  function automatic logic [1:0] ref_col(logic score, int h);
    if (!score || h >= 160) return 2'b00;
    return (h < 80) ? 2'b01 : 2'b10;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d (hcount=%0d)", req, got, exp, hcount);
    end
  endtask

  task automatic wr(logic [2:0] ad, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic sweep(logic [7:0] a, b, c, k);
    for (int h = 0; h < 170; h++) begin
      @(negedge clk);
      hcount = 8'(h);
      #1;
      chk(k[0] ? "R6 mirror" : "R4/R5 order", pf_on, ref_bit(a, b, c, k[0], h));
      chk("R7 col_sel", col_sel, ref_col(k[1], h));
      chk("R8 pf_front", pf_front, k[2]);
    end
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run ended)");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state over a whole line
    sweep(8'h00, 8'h00, 8'h00, 8'h00);

    // R3 R4 R5 R6: table walk
    for (int v = 0; v < 8; v++) begin
      wr(3'd0, VEC[v][31:24]);
      wr(3'd1, VEC[v][23:16]);
      wr(3'd2, VEC[v][15:8]);
      wr(3'd3, VEC[v][7:0]);
      sweep(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R6 hand spot: A bit4 only, mirror on -> last right slot lit
    wr(3'd1, 8'h00); wr(3'd2, 8'h00); wr(3'd0, 8'h10); wr(3'd3, 8'h01);
    @(negedge clk); hcount = 159; #1; chk("R6 end slot", pf_on, 1);
    @(negedge clk); hcount = 80;  #1; chk("R6 first right slot", pf_on, 0);
    @(negedge clk); hcount = 3;   #1; chk("R4 first slot", pf_on, 1);
    @(negedge clk); hcount = 4;   #1; chk("R3 slot edge", pf_on, 0);
    wr(3'd3, 8'h00);
    @(negedge clk); hcount = 80;  #1; chk("R5 repeat slot", pf_on, 1);
    @(negedge clk); hcount = 200; #1; chk("R9 blank", pf_on, 0);

    // R10 low nibble of A ignored
    wr(3'd0, 8'h0F);
    for (int h = 0; h < 16; h++) begin
      @(negedge clk); hcount = 8'(h); #1; chk("R10 low nibble", pf_on, 0);
    end

    // R2 ignored addresses 4..7
    for (int ad = 4; ad < 8; ad++) wr(3'(ad), 8'hFF);
    sweep(8'h00, 8'h00, 8'h00, 8'h00);

    // R11 mid-line write: slot 10 shows B bit 1
    @(negedge clk); hcount = 41; wr_en = 1; wr_addr = 3'd1; wr_data = 8'h02;
    #1; chk("R11 before edge", pf_on, 0);
    @(negedge clk); wr_en = 0; #1; chk("R11 after edge", pf_on, 1);
    @(negedge clk); hcount = 45; #1; chk("R11 other slot", pf_on, 0);

    // R1 reset clears again
    @(negedge clk); rst_n = 0; hcount = 41;
    @(negedge clk); rst_n = 1; #1;
    chk("R1 pf_on after reset", pf_on, 0);
    chk("R1 pf_front after reset", pf_front, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule